// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit and receive error counters of a CAN node and decides, from those counters, whether the node may take full part in bus traffic (error-active), must limit its error signalling (error-passive), or must stay off the bus entirely (bus-off). The protocol engine feeds it single-cycle strobes: a transmit error, a receive error, a successful transmit and a successful receive. It also feeds a sampled bus level together with a strobe that marks each bit time.

The counters, the state and a warning level are available at the ports at all times. The block also gives five single-cycle event pulses, each gated by its own enable input. A node that has gone bus-off returns to error-active by itself once the bus has shown enough idle. No command from outside is needed.

The state machine has three states. ST_ACTIVE is entered at reset. It moves to ST_PASSIVE when either counter is at or above 128, and to ST_BUSOFF when the transmit counter is at or above 256. ST_PASSIVE moves back to ST_ACTIVE when both counters are below 128, and to ST_BUSOFF when the transmit counter is at or above 256. ST_BUSOFF moves to ST_ACTIVE only when recovery completes. Every other case holds the current state.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, `state` reads 2'b00 (error-active), `warn` is 0 and `evt_pulse` is 0.
- R2: A `tx_err` strobe adds 8 to `tx_cnt` and an `rx_err` strobe adds 1 to `rx_cnt`, both visible the cycle after the strobe. When an error strobe and a success strobe hit the same counter in the same cycle, the error wins.
- R3: A `tx_ok` or `rx_ok` strobe subtracts 1 from the matching counter, and a counter at 0 stays at 0.
- R4: One cycle after either counter reaches 128 or more, while the transmit counter is below 256, `state` reads 2'b01 (error-passive).
- R5: One cycle after `tx_cnt` reaches 256 or more, `state` reads 2'b10 (bus-off).
- R6: While `tx_cnt` is at or above 256, and while in bus-off, all four event strobes leave both counters unchanged.
- R7: In bus-off, a bit time with `bit_stb`=1 and `bus_bit`=1 (recessive) extends the current run, and a bit with `bus_bit`=0 restarts it. Every run of 11 recessive bits counts one occurrence. On the bit that completes the 128th occurrence, both counters clear to 0 and `state` reads 2'b00 at the same edge. Cycles with `bit_stb`=0 do not count.
- R8: `warn` is 1 whenever either counter is at or above 96, and 0 only when both are below 96.
- R9: `evt_pulse` bits are: bit0 receive counter reaches 96, bit1 transmit counter reaches 96, bit2 receive counter reaches 128, bit3 transmit counter reaches 128, bit4 bus-off entered. Each bit pulses for one cycle on the rising edge of its condition, and only when the same bit of `evt_en` is 1.
- R10: From error-passive, `state` returns to 2'b00 one cycle after both counters are below 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error strobe |
| rx_err | input | 1 | Receive error strobe |
| tx_ok | input | 1 | Successful transmit strobe |
| rx_ok | input | 1 | Successful receive strobe |
| bit_stb | input | 1 | Marks a sampled bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| evt_en | input | 5 | Per-event pulse enables |
| tx_cnt | output | 9 | Transmit error counter |
| rx_cnt | output | 9 | Receive error counter |
| state | output | 2 | 00 active, 01 passive, 10 bus-off |
| warn | output | 1 | Warning level |
| evt_pulse | output | 5 | Single-cycle event pulses |

## Verification
The assertions assume that every strobe lasts one cycle and that `bus_bit` is only meaningful when `bit_stb` is high. They also assume that bus-off is reached only through transmit errors, because the receive counter is never driven far enough to saturate. The stimulus drives each strobe for exactly one cycle, changing inputs on the falling edge. It keeps the receive counter below 200, and it moves the transmit counter only by the steps the protocol engine would produce.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'b00,
        ST_PASSIVE = 2'b01,
        ST_BUSOFF  = 2'b10
    } fc_state_e;

    localparam int EV_RX_WARN = 0;
    localparam int EV_TX_WARN = 1;
    localparam int EV_RX_PASS = 2;
    localparam int EV_TX_PASS = 3;
    localparam int EV_BUSOFF  = 4;
    localparam int EV_NUM     = 5;
endpackage

// File: rtl/fc_err_ctr.sv
module fc_err_ctr #(
    parameter int CNT_W = 9,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr,
    input  logic             err,
    input  logic             ok,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] STEP_V = (CNT_W+1)'(STEP);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat_sum;

    always_comb begin
        sum     = {1'b0, cnt} + STEP_V;
        sat_sum = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr)               cnt <= '0;
        else if (hold)              cnt <= cnt;
        else if (err)               cnt <= sat_sum;
        else if (ok && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // R2: an error strobe adds the step (no saturation in normal use)
    a_r2_err_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !hold && !clr && !sum[CNT_W]) |=> (cnt == $past(sum[CNT_W-1:0])));
    // R3: counter never wraps below zero
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !err && !hold && !clr && cnt == '0) |=> (cnt == '0));
    // R6: frozen while held
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_stb,
    input  logic bus_bit,
    output logic done
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam int OCC_W = $clog2(RUN_COUNT);

    logic [RUN_W-1:0] run;
    logic [OCC_W-1:0] occ;
    logic             run_last;
    logic             occ_last;
    logic             rec_bit;

    always_comb begin
        run_last = (run == RUN_W'(RUN_LEN - 1));
        occ_last = (occ == OCC_W'(RUN_COUNT - 1));
        rec_bit  = enable && bit_stb && bus_bit;
        done     = rec_bit && run_last && occ_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run <= '0;
            occ <= '0;
        end else if (bit_stb) begin
            if (!bus_bit) begin
                run <= '0;
            end else if (run_last) begin
                run <= '0;
                occ <= occ + 1'b1;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // R7: a dominant bit restarts the run
    a_r7_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_stb && !bus_bit) |=> (run == '0));
    // R7: each completed run adds one occurrence
    a_r7_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_bit && run_last && !occ_last) |=> (occ == $past(occ) + 1'b1));
    // R7: idle cycles leave the run alone
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_stb && $past(enable)) |=> $stable(run));
endmodule

// File: rtl/fc_state_fsm.sv
module fc_state_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PASS_LIM = 128,
    parameter int BOFF_LIM = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             rec_done,
    output fc_state_e        state,
    output logic             in_boff
);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);

    fc_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE, ST_PASSIVE: begin
                if (tx_cnt >= BOFF_V)                          nxt = ST_BUSOFF;
                else if (tx_cnt >= PASS_V || rx_cnt >= PASS_V) nxt = ST_PASSIVE;
                else                                           nxt = ST_ACTIVE;
            end
            ST_BUSOFF: begin
                if (rec_done) nxt = ST_ACTIVE;
            end
            default: nxt = ST_ACTIVE;
        endcase
    end

    always_comb begin
        in_boff = (state == ST_BUSOFF);
    end

    // R5: bus-off is entered only from a transmit count at or above the limit
    a_r5_boff_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BUSOFF) ##1 (state == ST_BUSOFF) |-> ($past(tx_cnt) >= BOFF_V));
    // R7: bus-off is left only on recovery completion
    a_r7_boff_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSOFF && !rec_done) |=> (state == ST_BUSOFF));
    // R4: passive only with a counter at or above the passive limit
    a_r4_passive_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PASSIVE) ##1 (state == ST_PASSIVE) |->
        ($past(tx_cnt) >= PASS_V || $past(rx_cnt) >= PASS_V));
    // R10: both counters low brings passive back to active
    a_r10_back_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASSIVE && tx_cnt < PASS_V && rx_cnt < PASS_V) |=> (state == ST_ACTIVE));
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int TX_STEP   = 8,
    parameter int RX_STEP   = 1,
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 128,
    parameter int BOFF_LIM  = 256,
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_err,
    input  logic              rx_err,
    input  logic              tx_ok,
    input  logic              rx_ok,
    input  logic              bit_stb,
    input  logic              bus_bit,
    input  logic [4:0]        evt_en,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [1:0]        state,
    output logic              warn,
    output logic [4:0]        evt_pulse
);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);

    fc_state_e          st;
    logic               in_boff;
    logic               rec_done;
    logic               hold;
    logic [EV_NUM-1:0]  lvl;
    logic [EV_NUM-1:0]  lvl_q;

    always_comb begin
        hold = in_boff || (tx_cnt >= BOFF_V);
    end

    fc_err_ctr #(.CNT_W(CNT_W), .STEP(TX_STEP)) u_tx_ctr (
        .clk(clk), .rst_n(rst_n), .hold(hold), .clr(rec_done),
        .err(tx_err), .ok(tx_ok), .cnt(tx_cnt)
    );

    fc_err_ctr #(.CNT_W(CNT_W), .STEP(RX_STEP)) u_rx_ctr (
        .clk(clk), .rst_n(rst_n), .hold(hold), .clr(rec_done),
        .err(rx_err), .ok(rx_ok), .cnt(rx_cnt)
    );

    fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recovery (
        .clk(clk), .rst_n(rst_n), .enable(in_boff),
        .bit_stb(bit_stb), .bus_bit(bus_bit), .done(rec_done)
    );

    fc_state_fsm #(.CNT_W(CNT_W), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .rec_done(rec_done), .state(st), .in_boff(in_boff)
    );

    always_comb begin
        state               = st;
        warn                = (tx_cnt >= WARN_V) || (rx_cnt >= WARN_V);
        lvl[EV_RX_WARN]     = (rx_cnt >= WARN_V);
        lvl[EV_TX_WARN]     = (tx_cnt >= WARN_V);
        lvl[EV_RX_PASS]     = (rx_cnt >= PASS_V);
        lvl[EV_TX_PASS]     = (tx_cnt >= PASS_V);
        lvl[EV_BUSOFF]      = in_boff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar i = 0; i < EV_NUM; i++) begin : g_evt
        always_comb evt_pulse[i] = lvl[i] && !lvl_q[i] && evt_en[i];

        // R9: every event pulse lasts a single cycle
        a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[i] |=> !evt_pulse[i]);
    end

    // R8: warning stays up while a counter sits at or above the warning limit
    a_r8_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && !hold && !tx_ok && !rx_ok) |=> warn);
    // R1: reset leaves the node active with empty counters
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (state == 2'b00 && tx_cnt == '0 && rx_cnt == '0));
endmodule

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
    localparam int CLK_PER = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
    logic       bit_stb = 0, bus_bit = 0;
    logic [4:0] evt_en = 5'b11111;
    logic [8:0] tx_cnt, rx_cnt;
    logic [1:0] state;
    logic       warn;
    logic [4:0] evt_pulse;

    int n_chk = 0;
    int n_fail = 0;

    // {tx_err, rx_err, tx_ok, rx_ok, expected tx, expected rx}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'b0001, 9'd0,  9'd0},
        {4'b0010, 9'd0,  9'd0},
        {4'b1000, 9'd8,  9'd0},
        {4'b0100, 9'd8,  9'd1},
        {4'b1100, 9'd16, 9'd2},
        {4'b0011, 9'd15, 9'd1},
        {4'b1010, 9'd23, 9'd1},
        {4'b0001, 9'd23, 9'd0}
    };

    always #(CLK_PER/2) clk = ~clk;

    can_fault_conf dut (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_stb(bit_stb), .bus_bit(bus_bit),
        .evt_en(evt_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .state(state),
        .warn(warn), .evt_pulse(evt_pulse)
    );

    task automatic check(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    // drive one cycle of strobes after a falling edge, return at the next falling edge
    task automatic step(input logic te, input logic re, input logic to, input logic ro);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
    endtask

    task automatic bits(input int n, input logic lvl);
        for (int k = 0; k < n; k++) begin
            bit_stb = 1'b1; bus_bit = lvl;
            @(negedge clk);
            bit_stb = 1'b0; bus_bit = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_cnt", int'(tx_cnt), 0);
        check("R1 rx_cnt", int'(rx_cnt), 0);
        check("R1 state", int'(state), 0);
        check("R1 warn", int'(warn), 0);
        check("R1 evt_pulse", int'(evt_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 vector table
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18]);
            check($sformatf("R2/R3 vec%0d tx", v), int'(tx_cnt), int'(VEC[v][17:9]));
            check($sformatf("R2/R3 vec%0d rx", v), int'(rx_cnt), int'(VEC[v][8:0]));
        end

        // R8 / R9 transmit warning crossing: 23 -> 95 -> 103
        for (int k = 0; k < 9; k++) step(1, 0, 0, 0);
        check("R8 warn below 96", int'(warn), 0);
        step(1, 0, 0, 0);
        check("R2 tx 103", int'(tx_cnt), 103);
        check("R8 warn at 103", int'(warn), 1);
        check("R9 tx warn pulse", int'(evt_pulse), 5'b00010);
        @(negedge clk);
        check("R9 pulse one cycle", int'(evt_pulse), 0);

        // R4 transmit passive: 103 -> 135
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0);
        check("R9 tx passive pulse", int'(evt_pulse), 5'b01000);
        check("R4 state lags", int'(state), 0);
        @(negedge clk);
        check("R4 state passive", int'(state), 1);

        // R5 bus-off: 135 -> 255 -> 263
        for (int k = 0; k < 15; k++) step(1, 0, 0, 0);
        check("R5 tx 255", int'(tx_cnt), 255);
        check("R5 still passive", int'(state), 1);
        step(1, 0, 0, 0);
        check("R5 tx 263", int'(tx_cnt), 263);
        @(negedge clk);
        check("R5 state bus-off", int'(state), 2);
        check("R9 bus-off pulse", int'(evt_pulse), 5'b10000);

        // R6 strobes ignored in bus-off
        step(1, 1, 1, 1);
        step(0, 1, 1, 0);
        check("R6 tx frozen", int'(tx_cnt), 263);
        check("R6 rx frozen", int'(rx_cnt), 0);

        // R7 recovery: broken run, idle cycle, 127 full runs, then 10 bits
        bits(10, 1);
        bits(1, 0);
        @(negedge clk);
        bits(127 * 11, 1);
        bits(10, 1);
        check("R7 not yet recovered", int'(state), 2);
        @(negedge clk);
        check("R7 idle cycle not counted", int'(state), 2);
        bits(1, 1);
        check("R7 recovered state", int'(state), 0);
        check("R7 tx cleared", int'(tx_cnt), 0);
        check("R7 rx cleared", int'(rx_cnt), 0);
        check("R8 warn after recovery", int'(warn), 0);

        // R9 masked receive warning, receive passive
        evt_en = 5'b11110;
        for (int k = 0; k < 128; k++) begin
            step(0, 1, 0, 0);
            if (k == 95) begin
                check("R9 rx warn masked", int'(evt_pulse[0]), 0);
                check("R8 warn rx 96", int'(warn), 1);
            end
        end
        check("R9 rx passive pulse", int'(evt_pulse), 5'b00100);
        @(negedge clk);
        check("R4 rx passive", int'(state), 1);

        // R10 return to active, R8 warn clear below 96
        step(0, 0, 0, 1);
        @(negedge clk);
        check("R10 back active", int'(state), 0);
        check("R8 warn at 127", int'(warn), 1);
        for (int k = 0; k < 32; k++) step(0, 0, 0, 1);
        check("R3 rx 95", int'(rx_cnt), 95);
        check("R8 warn cleared", int'(warn), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule